// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a down-counting watchdog for a 50 MHz system domain. Software loads a reload value, starts the counter and then has to restart it at regular intervals. If a restart does not arrive before the count reaches zero, the active-low watchdog output falls. It stays low until a valid restart or a reset.

All writes go through a simple word-addressed register port. A write is accepted only when the upper 16 bits of the written word hold the key value 0x9876. Any other write leaves every register, the counter and the output unchanged, so software that has run away cannot silence or reprogram the watchdog by accident. The reload value is 32 bits wide and is written as two independently keyed 16-bit halves. The current count can be read back.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, both reload halves read 0xFFFF, the run flag reads 0, the counter reads 0xFFFFFFFF and `wdog_n` is 1.
- R2: A write to address 1 whose data bits 31:16 equal 0x9876 loads data bits 15:0 into the low reload half (reload bits 15:0).
- R3: A write to address 2 whose data bits 31:16 equal 0x9876 loads data bits 15:0 into the high reload half (reload bits 31:16).
- R4: A write to any address whose data bits 31:16 differ from 0x9876 changes no register, no count value and no output level.
- R5: A keyed write to address 0 sets the run flag to data bit 0. If data bit 1 is 1, the counter holds the combined 32-bit reload value from the next clock edge.
- R6: While the run flag is 1, the counter decreases by one on each clock edge and stops at 0. While the run flag is 0, it holds its value.
- R7: On the edge after the counter is seen at 0 with the run flag set, `wdog_n` goes to 0. It stays 0, even if the run flag is cleared, until a keyed trigger write restores it on that write's edge, or until a reset.
- R8: Reads are combinational. Address 0 returns the run flag in bit 0, with bit 1 and the key field reading 0. Addresses 1 and 2 return the reload half in bits 15:0 with bits 31:16 at 0. Address 3 returns the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 50 MHz working clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_addr | input | 2 | Word address of the write |
| wr_data | input | 32 | Write data; bits 31:16 carry the key |
| rd_addr | input | 2 | Word address of the read |
| rd_data | output | 32 | Read data for `rd_addr` |
| wdog_n | output | 1 | Watchdog output, low when expired |

## Verification
The main function is tried with several kinds of traffic:
- **Full-cycle run:** a small reload is counted all the way to expiry, which separates an off-by-one expiry edge from a correct one.
- **Pause and resume:** running is stopped and restarted mid-count, which shows whether the hold state really freezes the counter.
- **Wrong keys:** unkeyed trigger, run and reload writes are sent, including a key that differs by one bit. These tell a full 16-bit key comparison from a partial one.
- **Zero reload:** a reload of zero must expire on the very next edge.
- **Non-zero high half:** a reload with a non-zero high half shows that the two halves are joined in the right order.

A behavioural model in the bench predicts the read word and the output on every cycle, so an error in any single cycle is caught.

// File: rtl/wdt_pkg.sv
// Package wdt_pkg: shared constants for the keyed watchdog.
// Assumes a 32-bit register port with the key in the top 16 bits.
package wdt_pkg;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned KEY_W    = 16;
    localparam int unsigned CTRL_RUN = 0;
    localparam int unsigned CTRL_TRG = 1;
    localparam int unsigned ADDR_CTRL = 0;
endpackage

// File: rtl/wdt_keyed_regs.sv
// Module wdt_keyed_regs: key-checked register file.
// It holds the run flag and the reload value, which is split into HALF_W-bit halves.
// The half at index g sits at word address g+1; the control word sits at address 0.
// It also produces a one-cycle trigger request that is valid in the cycle of the write.
// Assumes HALF_W <= DATA_W - KEY_W and that the bus issues whole-word writes.
module wdt_keyed_regs
    import wdt_pkg::*;
#(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned HALF_W = 16,
    parameter int unsigned ADDR_W = 2,
    parameter logic [KEY_W-1:0] KEY = 16'h9876
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              run,
    output logic              trig,
    output logic [CNT_W-1:0]  reload_val
);
    localparam int unsigned NHALF = CNT_W / HALF_W;

    logic key_ok;
    logic accept;
    logic [HALF_W-1:0] half_q [NHALF];

    // Key comparison on the top field of the written word.
    assign key_ok = (wr_data[DATA_W-1 -: KEY_W] == KEY);
    assign accept = wr_en && key_ok;
    // Trigger request: keyed control write with the trigger bit set.
    assign trig   = accept && (wr_addr == ADDR_W'(ADDR_CTRL)) && wr_data[CTRL_TRG];

    // Run flag: updated only by a keyed control write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run <= 1'b0;
        else if (accept && (wr_addr == ADDR_W'(ADDR_CTRL)))
            run <= wr_data[CTRL_RUN];
    end

    generate
        for (genvar g = 0; g < NHALF; g++) begin : g_half
            // Reload half g: keyed write at address g+1.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    half_q[g] <= '1;
                else if (accept && (wr_addr == ADDR_W'(g + 1)))
                    half_q[g] <= wr_data[HALF_W-1:0];
            end
            assign reload_val[g*HALF_W +: HALF_W] = half_q[g];
        end
    endgenerate

    // R4: a write without the key leaves run flag and reload value untouched
    a_r4_unkeyed_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !key_ok) |=> ($stable(run) && $stable(reload_val)));

    // R2: keyed write to address 1 lands in the low half
    a_r2_low_half_load: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && wr_addr == ADDR_W'(1)) |=> (reload_val[HALF_W-1:0] == $past(wr_data[HALF_W-1:0])));

    // R3: keyed write to address 2 lands in the high half
    a_r3_high_half_load: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && wr_addr == ADDR_W'(2)) |=> (reload_val[2*HALF_W-1:HALF_W] == $past(wr_data[HALF_W-1:0])));
endmodule

// File: rtl/wdt_down_counter.sv
// Module wdt_down_counter: the down-counter and the sticky expiry flag.
// On a trigger it reloads and clears expiry. While running it counts down to 0
// and holds there. The expiry flag is set on the edge after a running zero is seen.
// Assumes trig is a single-cycle request.
module wdt_down_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             trig,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count,
    output logic             expired
);
    logic at_zero;
    assign at_zero = (count == '0);

    // Count register: reload on trigger, else step down while running.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '1;
        else if (trig)
            count <= reload_val;
        else if (run && !at_zero)
            count <= count - CNT_W'(1);
    end

    // Expiry flag: sticky until trigger or reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            expired <= 1'b0;
        else if (trig)
            expired <= 1'b0;
        else if (run && at_zero)
            expired <= 1'b1;
    end

    // R5: trigger loads the reload value
    a_r5_trigger_load: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (count == $past(reload_val)));

    // R6: one step down per running cycle
    a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !trig && count != '0) |=> (count == $past(count) - CNT_W'(1)));

    // R6: stopped counter holds
    a_r6_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !trig) |=> $stable(count));

    // R7: expiry is sticky without a trigger
    a_r7_expiry_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !trig) |=> expired);
endmodule

// File: rtl/keyed_watchdog.sv
// Module keyed_watchdog: top level of the key-protected watchdog.
// Joins the keyed register file and the counter, drives the active-low output
// and provides the combinational read mux (0 control, 1/2 reload halves, 3 count).
// Assumes a 50 MHz clock and a synchronous active-low reset.
module keyed_watchdog
    import wdt_pkg::*;
#(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned HALF_W = 16,
    parameter logic [KEY_W-1:0] KEY = 16'h9876
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              wdog_n
);
    localparam int unsigned ADDR_W = 2;

    logic             run;
    logic             trig;
    logic [CNT_W-1:0] reload_val;
    logic [CNT_W-1:0] count;
    logic             expired;

    wdt_keyed_regs #(
        .CNT_W(CNT_W), .HALF_W(HALF_W), .ADDR_W(ADDR_W), .KEY(KEY)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .run(run), .trig(trig), .reload_val(reload_val)
    );

    wdt_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(run), .trig(trig),
        .reload_val(reload_val), .count(count), .expired(expired)
    );

    assign wdog_n = ~expired;

    // Read mux; key field and trigger bit always read as zero.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            2'd0:    rd_data[CTRL_RUN] = run;
            2'd1:    rd_data[HALF_W-1:0] = reload_val[HALF_W-1:0];
            2'd2:    rd_data[HALF_W-1:0] = reload_val[2*HALF_W-1:HALF_W];
            default: rd_data = DATA_W'(count);
        endcase
    end

    // R7: running zero pulls the output low on the next edge
    a_r7_output_falls: assert property (@(posedge clk) disable iff (!rst_n)
        (run && count == '0 && !trig) |=> !wdog_n);

    // R7: a trigger always releases the output
    a_r7_trigger_release: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> wdog_n);
endmodule

// File: tb/tb_keyed_watchdog.sv
// Bench for keyed_watchdog: a behavioural model compared on every cycle, plus directed checks.
module tb_keyed_watchdog;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = 2'd3;
    logic [31:0] rd_data;
    logic        wdog_n;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    // behavioural model state
    logic [15:0] m_lo, m_hi;
    logic [31:0] m_cnt;
    bit          m_run, m_exp;

    always #5 clk = ~clk;

    keyed_watchdog dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .wdog_n(wdog_n)
    );

    function automatic logic [31:0] m_read(input logic [1:0] a);
        case (a)
            2'd0: return {31'd0, m_run};
            2'd1: return {16'd0, m_lo};
            2'd2: return {16'd0, m_hi};
            default: return m_cnt;
        endcase
    endfunction

    // model update on each edge
    always @(posedge clk) begin
        bit keyed, trg;
        if (!rst_n) begin
            m_lo = 16'hFFFF; m_hi = 16'hFFFF; m_cnt = 32'hFFFF_FFFF;
            m_run = 0; m_exp = 0;
        end else begin
            keyed = wr_en && (wr_data[31:16] == 16'h9876);
            trg = keyed && wr_addr == 2'd0 && wr_data[1];
            if (trg) begin
                m_cnt = {m_hi, m_lo}; m_exp = 0;
            end else begin
                if (m_run && m_cnt == 0) m_exp = 1;
                if (m_run && m_cnt != 0) m_cnt = m_cnt - 1;
            end
            if (keyed && wr_addr == 2'd0) m_run = wr_data[0];
            if (keyed && wr_addr == 2'd1) m_lo = wr_data[15:0];
            if (keyed && wr_addr == 2'd2) m_hi = wr_data[15:0];
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            checks++;
            if (rd_data !== m_read(rd_addr) || wdog_n !== !m_exp) begin
                fails++;
                $display("FAIL R6/R7/R8 cycle %0d addr %0d: actual rd %h wdog_n %b, expected rd %h wdog_n %b",
                         cyc, rd_addr, rd_data, wdog_n, m_read(rd_addr), !m_exp);
            end
        end
    end

    // watchdog of the bench
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            fails++; checks++;
            $display("FAIL watchdog: run hung, actual cycle %0d expected below 100000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0; wr_data = '0;
    endtask

    // read now, without waiting for an edge
    task automatic rd_now(input string tag, input logic [1:0] a, input logic [31:0] exp);
        rd_addr = a; #3;
        chk(tag, rd_data, exp);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        idle(3);
        rst_n = 1;
        @(negedge clk);
        rd_now("R1 low half", 2'd1, 32'h0000_FFFF);
        rd_now("R1 high half", 2'd2, 32'h0000_FFFF);
        rd_now("R1 run flag", 2'd0, 32'h0);
        rd_now("R1 count", 2'd3, 32'hFFFF_FFFF);
        chk("R1 wdog_n", {31'd0, wdog_n}, 32'd1);

        wr(2'd1, 32'h1234_0010);
        rd_now("R4 unkeyed low write", 2'd1, 32'h0000_FFFF);
        wr(2'd0, 32'h9877_0003);
        rd_now("R4 near-key control write run", 2'd0, 32'h0);
        rd_now("R4 near-key control count", 2'd3, 32'hFFFF_FFFF);

        wr(2'd1, 32'h9876_0020);
        rd_now("R2 keyed low write / R8 zero key field", 2'd1, 32'h0000_0020);
        wr(2'd2, 32'h9876_0000);
        rd_now("R3 keyed high write", 2'd2, 32'h0);
        wr(2'd2, 32'h9875_0001);
        rd_now("R4 unkeyed high write", 2'd2, 32'h0);

        wr(2'd0, 32'h9876_0003);
        rd_now("R5 trigger loads reload", 2'd3, 32'h0000_0020);
        chk("R7 released after trigger", {31'd0, wdog_n}, 32'd1);
        wr(2'd0, 32'h9876_0000);
        rd_now("R6 count after two running edges", 2'd3, 32'h0000_001E);
        idle(3);
        rd_now("R6 stopped count holds", 2'd3, 32'h0000_001E);
        rd_now("R8 run flag cleared", 2'd0, 32'h0);
        wr(2'd0, 32'h9876_0001);
        rd_now("R8 run flag set, trigger bit reads 0", 2'd0, 32'h1);
        rd_addr = 2'd3;
        idle(40);
        rd_now("R6 count stops at zero", 2'd3, 32'h0);
        chk("R7 expired output low", {31'd0, wdog_n}, 32'd0);

        wr(2'd0, 32'h9876_0000);
        idle(4);
        chk("R7 stays low with run cleared", {31'd0, wdog_n}, 32'd0);
        wr(2'd0, 32'h0000_0003);
        idle(2);
        chk("R4 unkeyed trigger keeps output low", {31'd0, wdog_n}, 32'd0);

        wr(2'd1, 32'h9876_0000);
        wr(2'd0, 32'h9876_0003);
        chk("R7 released on zero-reload trigger", {31'd0, wdog_n}, 32'd1);
        @(negedge clk); #3;
        chk("R7 zero reload expires next edge", {31'd0, wdog_n}, 32'd0);

        wr(2'd1, 32'h9876_0005);
        wr(2'd2, 32'h9876_0001);
        wr(2'd0, 32'h9876_0002);
        rd_now("R5 halves joined high:low", 2'd3, 32'h0001_0005);
        wr(2'd0, 32'h9876_0001);
        idle(10);

        @(negedge clk); rst_n = 0;
        idle(2);
        rst_n = 1;
        @(negedge clk);
        rd_now("R1 low half after reset", 2'd1, 32'h0000_FFFF);
        rd_now("R1 count after reset", 2'd3, 32'hFFFF_FFFF);
        chk("R1 wdog_n after reset", {31'd0, wdog_n}, 32'd1);

        idle(2);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule